// File: doc/BRIEF.md
# PCIe Address Translation Window Unit

This block keeps a bank of programmable address translation windows for a PCIe root port. There are two sets of windows. The outbound set translates CPU addresses into PCIe addresses. The inbound set translates PCIe addresses into CPU addresses. Software reaches every window through one select register and a single shared group of window registers. The select register chooses the direction and the window index. Reads and writes at the shared offsets then act on the window it names.

Window settings are staged as software writes them. They reach the lookup path only when the second control word is written, so a window is never seen half-programmed. A combinational lookup port takes an address and a direction bit. It returns a hit flag, the window kind and the translated address. For a configuration-access window it also returns the bus number and the device/function number taken from the window target.

Top module: `xlat_window_unit`

## Requirements
- R1: The select register sits at offset 0x900. Bit 31 selects the inbound set (1) or the outbound set (0). Bits [IDX_W-1:0] hold the window index. Reading it back returns the stored value. After reset it reads 0.
- R2: A write to the select register clears every bit except bit 31 and the index bits. The index is masked to NUM_WIN-1. With 16 windows, writing 0xFFFFFFFF reads back as 0x8000000F.
- R3: Each window has its own staged copy of seven registers: control A at 0x904, control B at 0x908, base low at 0x90C, base high at 0x910, limit at 0x914, target low at 0x918 and target high at 0x91C. Reads at these offsets return the staged value of the selected window. Every direction and index has separate storage.
- R4: Writes to control A, base, limit or target do not change the lookup result until control B of that window is written. Writing control B commits all staged fields at once.
- R5: Bit 31 of control B is the window enable. A committed window with the enable cleared never hits.
- R6: A memory window has control A equal to 0. It hits when the address upper 32 bits equal the base upper 32 bits and the lower 32 bits lie between the base low word and the limit, inclusive. It returns target + (address - base), with lk_cfg = 0 and bus and devfn both 0.
- R7: A configuration window has a nonzero control A. On a hit it returns lk_cfg = 1, the offset address - base, the bus from target bits [31:24] and the devfn from target bits [23:16].
- R8: When several enabled windows of the selected direction match, the lowest index wins.
- R9: On a miss, lk_hit, lk_cfg, lk_xlat, lk_bus and lk_devfn are all 0.
- R10: After reset every window has base 0, target 0, limit 0xFFFFFFFF, control A 0 and control B 0. The exception is inbound window 0, whose control B is 0x80000000 and which is committed enabled. Any inbound address below 4 GiB therefore passes through unchanged.
- R11: lk_inbound chooses which set is searched. No outbound window is enabled after reset.
- R12: Reads at any other offset return 0. Writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| lk_addr | input | 64 | Address to translate |
| lk_inbound | input | 1 | 1 = search the inbound set, 0 = search the outbound set |
| lk_hit | output | 1 | A window matched |
| lk_cfg | output | 1 | The matching window is a configuration window |
| lk_xlat | output | 64 | Translated address or configuration offset |
| lk_bus | output | 8 | Bus number for configuration windows |
| lk_devfn | output | 8 | Device/function number for configuration windows |

## Verification
The hardest case to reach from the ports is a window whose staged and committed contents differ while a lookup is under way. Only that case shows that staging really isolates the lookup path. The stimulus first commits a memory window. It then rewrites the target of that window without touching control B and checks that lookups still use the old target while readback already shows the new one. A second, overlapping configuration window at a lower index is also committed. This makes priority decide between two live hits, and the stimulus probes addresses inside only one window and inside both.

// File: rtl/xwu_pkg.sv
`timescale 1ns/1ps
package xwu_pkg;

   localparam int CFG_AW = 12;

   localparam logic [CFG_AW-1:0] OFS_SELECT  = 12'h900;
   localparam logic [CFG_AW-1:0] OFS_CTLA    = 12'h904;
   localparam logic [CFG_AW-1:0] OFS_CTLB    = 12'h908;
   localparam logic [CFG_AW-1:0] OFS_BASE_LO = 12'h90C;
   localparam logic [CFG_AW-1:0] OFS_BASE_HI = 12'h910;
   localparam logic [CFG_AW-1:0] OFS_LIMIT   = 12'h914;
   localparam logic [CFG_AW-1:0] OFS_TGT_LO  = 12'h918;
   localparam logic [CFG_AW-1:0] OFS_TGT_HI  = 12'h91C;

   typedef enum logic [2:0] {
      FLD_CTLA, FLD_CTLB, FLD_BASE_LO, FLD_BASE_HI,
      FLD_LIMIT, FLD_TGT_LO, FLD_TGT_HI, FLD_NONE
   } win_field_e;

   typedef struct packed {
      logic [31:0] ctla;
      logic [31:0] ctlb;
      logic [63:0] base;
      logic [31:0] limit;
      logic [63:0] target;
   } win_regs_t;

   function automatic win_field_e field_of(input logic [CFG_AW-1:0] ofs);
      case (ofs)
         OFS_CTLA:    return FLD_CTLA;
         OFS_CTLB:    return FLD_CTLB;
         OFS_BASE_LO: return FLD_BASE_LO;
         OFS_BASE_HI: return FLD_BASE_HI;
         OFS_LIMIT:   return FLD_LIMIT;
         OFS_TGT_LO:  return FLD_TGT_LO;
         OFS_TGT_HI:  return FLD_TGT_HI;
         default:     return FLD_NONE;
      endcase
   endfunction

   function automatic logic [31:0] field_read(input win_regs_t r, input win_field_e f);
      case (f)
         FLD_CTLA:    return r.ctla;
         FLD_CTLB:    return r.ctlb;
         FLD_BASE_LO: return r.base[31:0];
         FLD_BASE_HI: return r.base[63:32];
         FLD_LIMIT:   return r.limit;
         FLD_TGT_LO:  return r.target[31:0];
         FLD_TGT_HI:  return r.target[63:32];
         default:     return 32'h0;
      endcase
   endfunction

endpackage

// File: rtl/xwu_select.sv
`timescale 1ns/1ps
module xwu_select #(
   parameter int NUM_WIN = 16,
   localparam int IDX_W = $clog2(NUM_WIN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic             wr_dir,
   input  logic [IDX_W-1:0] wr_idx,
   output logic             sel_inbound,
   output logic [IDX_W-1:0] sel_idx,
   output logic [31:0]      sel_word
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_inbound <= 1'b0;
         sel_idx     <= '0;
      end else if (we) begin
         sel_inbound <= wr_dir;
         sel_idx     <= wr_idx;
      end
   end

   assign sel_word = {sel_inbound, {(31-IDX_W){1'b0}}, sel_idx};

endmodule

// File: rtl/xwu_window.sv
`timescale 1ns/1ps
module xwu_window
   import xwu_pkg::*;
#(
   parameter bit RESET_EN = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  win_field_e  wr_field,
   input  logic [31:0] wdata,
   input  logic [63:0] lk_addr,
   output win_regs_t   staged,
   output logic        match,
   output logic        is_cfg,
   output logic [63:0] xlat,
   output logic [7:0]  bus,
   output logic [7:0]  devfn
);

   localparam logic [31:0] CTLB_RST = RESET_EN ? 32'h8000_0000 : 32'h0;

   logic        c_en;
   logic        c_cfg;
   logic [63:0] c_base;
   logic [31:0] c_limit;
   logic [63:0] c_target;
   logic [63:0] offset;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         staged <= '{ctla: 32'h0, ctlb: CTLB_RST, base: 64'h0,
                     limit: 32'hFFFF_FFFF, target: 64'h0};
      end else if (wr_en) begin
         case (wr_field)
            FLD_CTLA:    staged.ctla          <= wdata;
            FLD_CTLB:    staged.ctlb          <= wdata;
            FLD_BASE_LO: staged.base[31:0]    <= wdata;
            FLD_BASE_HI: staged.base[63:32]   <= wdata;
            FLD_LIMIT:   staged.limit         <= wdata;
            FLD_TGT_LO:  staged.target[31:0]  <= wdata;
            FLD_TGT_HI:  staged.target[63:32] <= wdata;
            default: ;
         endcase
      end
   end

   // commit point: control B write publishes every staged field at once
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         c_en     <= RESET_EN;
         c_cfg    <= 1'b0;
         c_base   <= 64'h0;
         c_limit  <= 32'hFFFF_FFFF;
         c_target <= 64'h0;
      end else if (wr_en && wr_field == FLD_CTLB) begin
         c_en     <= wdata[31];
         c_cfg    <= (staged.ctla != 32'h0);
         c_base   <= staged.base;
         c_limit  <= staged.limit;
         c_target <= staged.target;
      end
   end

   assign offset = lk_addr - c_base;
   assign match  = c_en && (lk_addr[63:32] == c_base[63:32])
                        && (lk_addr[31:0] >= c_base[31:0])
                        && (lk_addr[31:0] <= c_limit);
   assign is_cfg = c_cfg;
   assign xlat   = c_cfg ? offset : (c_target + offset);
   assign bus    = c_cfg ? c_target[31:24] : 8'h0;
   assign devfn  = c_cfg ? c_target[23:16] : 8'h0;

   AST_COMMIT_ONLY_ON_CTLB: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_field == FLD_CTLB) |=> ($stable(c_en) && $stable(c_cfg) && $stable(c_base)
                                            && $stable(c_limit) && $stable(c_target))); // R4

   AST_DISABLED_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_field == FLD_CTLB && !wdata[31]) |=> !match); // R5

endmodule

// File: rtl/xwu_prio_pick.sv
`timescale 1ns/1ps
module xwu_prio_pick #(
   parameter int N = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic [N-1:0] grant
);

   logic [N-1:0] below;

   assign below[0] = 1'b0;
   for (genvar i = 1; i < N; i++) begin : g_chain
      assign below[i] = below[i-1] | req[i-1];
   end

   for (genvar i = 0; i < N; i++) begin : g_grant
      assign grant[i] = req[i] & ~below[i];

      AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         grant[i] |-> ((req << (N - i)) == '0)); // R8
   end

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |-> ($countones(grant) == 1)); // R8

   AST_GRANT_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R8

endmodule

// File: rtl/xlat_window_unit.sv
`timescale 1ns/1ps
module xlat_window_unit
   import xwu_pkg::*;
#(
   parameter int NUM_WIN = 16,
   localparam int IDX_W = $clog2(NUM_WIN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic [63:0]       lk_addr,
   input  logic              lk_inbound,
   output logic              lk_hit,
   output logic              lk_cfg,
   output logic [63:0]       lk_xlat,
   output logic [7:0]        lk_bus,
   output logic [7:0]        lk_devfn
);

   initial begin
      assert (NUM_WIN >= 2 && NUM_WIN <= 256 && (NUM_WIN & (NUM_WIN - 1)) == 0)
         else $error("NUM_WIN must be a power of two between 2 and 256");
   end

   logic             sel_inbound;
   logic [IDX_W-1:0] sel_idx;
   logic [31:0]      sel_word;
   logic             sel_we;
   win_field_e       fld;

   assign fld    = field_of(cfg_addr);
   assign sel_we = cfg_we && (cfg_addr == OFS_SELECT);

   xwu_select #(.NUM_WIN(NUM_WIN)) u_select (
      .clk         (clk),
      .rst_n       (rst_n),
      .we          (sel_we),
      .wr_dir      (cfg_wdata[31]),
      .wr_idx      (cfg_wdata[IDX_W-1:0]),
      .sel_inbound (sel_inbound),
      .sel_idx     (sel_idx),
      .sel_word    (sel_word)
   );

   // index 0 = outbound set, index 1 = inbound set
   win_regs_t          stg_a   [2][NUM_WIN];
   logic [63:0]        xlat_a  [2][NUM_WIN];
   logic [7:0]         bus_a   [2][NUM_WIN];
   logic [7:0]         devfn_a [2][NUM_WIN];
   logic [NUM_WIN-1:0] match_v [2];
   logic [NUM_WIN-1:0] cfg_v   [2];
   logic [NUM_WIN-1:0] grant_v [2];

   for (genvar d = 0; d < 2; d++) begin : g_dir
      for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
         logic we_i;
         assign we_i = cfg_we && (fld != FLD_NONE)
                       && (sel_inbound == 1'(d)) && (sel_idx == IDX_W'(i));

         xwu_window #(.RESET_EN((d == 1) && (i == 0))) u_win (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (we_i),
            .wr_field (fld),
            .wdata    (cfg_wdata),
            .lk_addr  (lk_addr),
            .staged   (stg_a[d][i]),
            .match    (match_v[d][i]),
            .is_cfg   (cfg_v[d][i]),
            .xlat     (xlat_a[d][i]),
            .bus      (bus_a[d][i]),
            .devfn    (devfn_a[d][i])
         );
      end

      xwu_prio_pick #(.N(NUM_WIN)) u_pick (
         .clk   (clk),
         .rst_n (rst_n),
         .req   (match_v[d]),
         .grant (grant_v[d])
      );
   end

   // register readback
   always_comb begin
      if (cfg_addr == OFS_SELECT) cfg_rdata = sel_word;
      else if (fld != FLD_NONE)   cfg_rdata = field_read(stg_a[sel_inbound][sel_idx], fld);
      else                        cfg_rdata = 32'h0;
   end

   // lookup: AND-OR merge of the granted window
   logic [NUM_WIN-1:0] gsel;
   assign gsel = grant_v[lk_inbound];

   always_comb begin
      lk_cfg   = 1'b0;
      lk_xlat  = 64'h0;
      lk_bus   = 8'h0;
      lk_devfn = 8'h0;
      for (int i = 0; i < NUM_WIN; i++) begin
         if (gsel[i]) begin
            lk_cfg   = lk_cfg   | cfg_v[lk_inbound][i];
            lk_xlat  = lk_xlat  | xlat_a[lk_inbound][i];
            lk_bus   = lk_bus   | bus_a[lk_inbound][i];
            lk_devfn = lk_devfn | devfn_a[lk_inbound][i];
         end
      end
   end
   assign lk_hit = |gsel;

   AST_SELECT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      sel_we |=> ((sel_word & ~{1'b1, {(31-IDX_W){1'b0}}, {IDX_W{1'b1}}}) == 32'h0)); // R2

   AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (!lk_cfg && lk_xlat == 64'h0 && lk_bus == 8'h0 && lk_devfn == 8'h0)); // R9

   AST_HIT_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (match_v[lk_inbound] != '0)); // R11

   AST_MEM_NO_IDS: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit && !lk_cfg) |-> (lk_bus == 8'h0 && lk_devfn == 8'h0)); // R6

endmodule

// File: tb/xlat_window_unit_bench.sv
`timescale 1ns/1ps
module xlat_window_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [11:0] cfg_addr = 12'h0;
   logic [31:0] cfg_wdata = 32'h0;
   logic [31:0] cfg_rdata;
   logic [63:0] lk_addr = 64'h0;
   logic        lk_inbound = 1'b0;
   logic        lk_hit;
   logic        lk_cfg;
   logic [63:0] lk_xlat;
   logic [7:0]  lk_bus;
   logic [7:0]  lk_devfn;

   always #5 clk = ~clk;

   xlat_window_unit u_xlat_window_unit (
      .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
      .lk_addr, .lk_inbound, .lk_hit, .lk_cfg, .lk_xlat, .lk_bus, .lk_devfn
   );

   typedef struct packed {
      logic        is_rd;
      logic [31:0] rd;
      logic        hit;
      logic        cfg;
      logic [63:0] xl;
      logic [7:0]  bus;
      logic [7:0]  devfn;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    n_checks = 0;
   int    n_fail   = 0;

   // monitor: compares 3 ns after the falling edge on which the item was driven
   initial begin
      forever begin
         @(negedge clk);
         #3;
         while (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (e.is_rd) begin
               if (cfg_rdata !== e.rd) begin
                  n_fail++;
                  $display("FAIL %s rdata actual %h expected %h", t, cfg_rdata, e.rd);
               end
            end else if ({lk_hit, lk_cfg, lk_xlat, lk_bus, lk_devfn} !==
                         {e.hit, e.cfg, e.xl, e.bus, e.devfn}) begin
               n_fail++;
               $display("FAIL %s lookup actual hit=%b cfg=%b xlat=%h bus=%h devfn=%h expected hit=%b cfg=%b xlat=%h bus=%h devfn=%h",
                        t, lk_hit, lk_cfg, lk_xlat, lk_bus, lk_devfn,
                        e.hit, e.cfg, e.xl, e.bus, e.devfn);
            end
         end
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd_chk(input logic [11:0] a, input logic [31:0] e, input string t);
      exp_t x;
      @(negedge clk);
      cfg_addr = a;
      x = '0; x.is_rd = 1'b1; x.rd = e;
      exp_q.push_back(x); tag_q.push_back(t);
   endtask

   task automatic lk_chk(input logic [63:0] a, input logic inb, input logic h, input logic c,
                         input logic [63:0] xl, input logic [7:0] b, input logic [7:0] df,
                         input string t);
      exp_t x;
      @(negedge clk);
      lk_addr = a; lk_inbound = inb;
      x = '0; x.hit = h; x.cfg = c; x.xl = xl; x.bus = b; x.devfn = df;
      exp_q.push_back(x); tag_q.push_back(t);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      rd_chk(12'h900, 32'h0, "R1 select reset");
      lk_chk(64'h1000, 1'b0, 0, 0, 64'h0, 8'h0, 8'h0, "R11 outbound empty at reset");
      wr(12'h900, 32'h8000_0000);
      rd_chk(12'h900, 32'h8000_0000, "R1 select readback");
      rd_chk(12'h908, 32'h8000_0000, "R10 inbound 0 ctlb");
      rd_chk(12'h914, 32'hFFFF_FFFF, "R10 limit reset");
      rd_chk(12'h90C, 32'h0, "R10 base reset");
      lk_chk(64'h1234_5678, 1'b1, 1, 0, 64'h1234_5678, 8'h0, 8'h0, "R10 inbound passthrough");
      lk_chk(64'h1_0000_0000, 1'b1, 0, 0, 64'h0, 8'h0, 8'h0, "R9 inbound above 4G miss");

      // select masking
      wr(12'h900, 32'hFFFF_FFFF);
      rd_chk(12'h900, 32'h8000_000F, "R2 mask all ones");
      wr(12'h900, 32'h7FFF_FF23);
      rd_chk(12'h900, 32'h0000_0003, "R2 mask index");

      // outbound window 3: memory
      wr(12'h90C, 32'h4000_0000);
      wr(12'h910, 32'h0000_0001);
      wr(12'h914, 32'h4000_FFFF);
      wr(12'h918, 32'h0000_2000);
      wr(12'h904, 32'h0);
      rd_chk(12'h90C, 32'h4000_0000, "R3 staged base readback");
      lk_chk(64'h1_4000_0010, 1'b0, 0, 0, 64'h0, 8'h0, 8'h0, "R4 before commit");
      wr(12'h908, 32'h8000_0000);
      lk_chk(64'h1_4000_0010, 1'b0, 1, 0, 64'h2010, 8'h0, 8'h0, "R6 mem hit");
      lk_chk(64'h1_4000_FFFF, 1'b0, 1, 0, 64'h1_1FFF, 8'h0, 8'h0, "R6 at limit");
      lk_chk(64'h1_4001_0000, 1'b0, 0, 0, 64'h0, 8'h0, 8'h0, "R6 above limit");
      lk_chk(64'h1_3FFF_FFFF, 1'b0, 0, 0, 64'h0, 8'h0, 8'h0, "R6 below base");
      lk_chk(64'h0_4000_0010, 1'b0, 0, 0, 64'h0, 8'h0, 8'h0, "R6 upper word differs");
      lk_chk(64'h1_4000_0010, 1'b1, 0, 0, 64'h0, 8'h0, 8'h0, "R11 inbound set not used");

      // outbound window 1: configuration, overlapping window 3
      wr(12'h900, 32'h0000_0001);
      wr(12'h90C, 32'h4000_8000);
      wr(12'h910, 32'h0000_0001);
      wr(12'h914, 32'h4000_8FFF);
      wr(12'h918, 32'h0A28_0000);
      wr(12'h904, 32'h0000_0004);
      wr(12'h908, 32'h8000_0000);
      lk_chk(64'h1_4000_8044, 1'b0, 1, 1, 64'h44, 8'h0A, 8'h28, "R7 R8 cfg window wins");
      lk_chk(64'h1_4000_9000, 1'b0, 1, 0, 64'hB000, 8'h0, 8'h0, "R8 only window 3");

      // staged target does not leak before commit
      wr(12'h900, 32'h0000_0003);
      wr(12'h918, 32'h0000_5000);
      lk_chk(64'h1_4000_0010, 1'b0, 1, 0, 64'h2010, 8'h0, 8'h0, "R4 old target kept");
      rd_chk(12'h918, 32'h0000_5000, "R3 staged target readback");
      wr(12'h908, 32'h8000_0000);
      lk_chk(64'h1_4000_0010, 1'b0, 1, 0, 64'h5010, 8'h0, 8'h0, "R4 new target after commit");

      // disable window 3
      wr(12'h908, 32'h0);
      lk_chk(64'h1_4000_0010, 1'b0, 0, 0, 64'h0, 8'h0, 8'h0, "R5 disabled miss");
      rd_chk(12'h908, 32'h0, "R5 ctlb readback");

      // separate storage per direction
      wr(12'h900, 32'h8000_0003);
      rd_chk(12'h90C, 32'h0, "R3 inbound 3 base untouched");
      rd_chk(12'h918, 32'h0, "R11 inbound 3 target untouched");

      // unknown offsets
      wr(12'h920, 32'hFFFF_FFFF);
      rd_chk(12'h920, 32'h0, "R12 unknown reads zero");
      rd_chk(12'h900, 32'h8000_0003, "R12 select unchanged");
      rd_chk(12'h904, 32'h0, "R12 window unchanged");

      // inbound window 0 disable
      wr(12'h900, 32'h8000_0000);
      wr(12'h908, 32'h0);
      lk_chk(64'h100, 1'b1, 0, 0, 64'h0, 8'h0, 8'h0, "R5 inbound 0 disabled");

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule